// File: doc/BRIEF.md
# Serial Divider-Word Programming Port

This block receives divider settings for a frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. Bits are taken in on rising serial-clock edges, most significant first, while the load strobe is low. Raising the load strobe ends the frame. The two bits shifted in last act as a routing code: one code writes a 17-bit reference-divider word and another writes an 18-bit comparator-divider word. Each word has a valid flag that rises on its first accepted write.

All three serial wires are brought into the system clock domain through synchroniser chains, and all timing decisions are made there. A comparator frame carries a 3-bit test field ahead of its divider bits, and that field must be zero. If the field is not zero, the frame is refused and a sticky error flag is set. A write only happens if the serial clock and data lines are both low when the strobe rises. It also requires the frame length to match the selected word exactly. The staging register is emptied on every strobe, so a partial frame never mixes with the next one.

Top module: `synth_prog_port`

## Requirements
- R1: After reset, `refValid`, `cmpValid` and `prefixErr` are 0, and `refWord` and `cmpWord` are all zeros.
- R2: While `serLoad` is low, each rising edge of `serClk` appends the level of `serData` to the frame. The first bit shifted is the most significant bit of the frame.
- R3: A 19-bit frame whose final two bits are 1,1 writes the first 17 bits (MSB first) to `refWord` and sets `refValid`.
- R4: A 23-bit frame whose final two bits are 0,1 and whose first three bits are 0,0,0 writes bits 4 to 21 (MSB first) to `cmpWord` and sets `cmpValid`.
- R5: Routing codes 0,0 and 1,0 update neither word nor either valid flag.
- R6: A 23-bit frame with code 0,1 and a nonzero 3-bit test field leaves `cmpWord` and `cmpValid` unchanged and sets `prefixErr`.
- R7: When `serLoad` rises while `serClk` is high or `serData` is high, no word is written.
- R8: A frame whose bit count does not match the selected word (19 for reference, 23 for comparator) writes nothing.
- R9: Every rising edge of `serLoad` empties the staged bits, so a partial frame followed by a strobe does not affect the next frame.
- R10: A write to one word leaves the other word and its valid flag unchanged.
- R11: `prefixErr` stays set until reset, including across later accepted frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data line (asynchronous) |
| serLoad | input | 1 | Load strobe, low while shifting (asynchronous) |
| refWord | output | 17 | Reference-divider word |
| refValid | output | 1 | Reference word has been written |
| cmpWord | output | 18 | Comparator-divider word |
| cmpValid | output | 1 | Comparator word has been written |
| prefixErr | output | 1 | Sticky flag for a refused test field |

## Verification
A wrong bit count or a misaligned staging register shows up at the ports only on the next strobe. It appears as a frame refused that should have been accepted, or as a word written with its bits shifted by one place. Each frame's outcome can be read a few system clocks after the strobe rises. The bench therefore compares every output after every frame, including the rejected frames, where a wrongly accepted frame shows up as a changed word. A stale staging register is exposed by sending a partial frame and then a full one.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  localparam int REF_W    = 17;
  localparam int CMP_W    = 18;
  localparam int PREFIX_W = 3;
  localparam int CODE_W   = 2;

  localparam logic [CODE_W-1:0] CODE_REF = 2'b11;
  localparam logic [CODE_W-1:0] CODE_CMP = 2'b01;

  typedef struct packed {
    logic shift;
    logic clear;
    logic loadRef;
    logic loadCmp;
    logic flagErr;
  } dpStrobe_t;

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import synth_prog_pkg::*;
#(
  parameter int REF_LEN  = REF_W + CODE_W,
  parameter int CMP_LEN  = PREFIX_W + CMP_W + CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sClk,
  input  logic                sData,
  input  logic                sLoad,
  input  logic [CODE_W-1:0]   frameCode,
  input  logic [PREFIX_W-1:0] framePrefix,
  output dpStrobe_t           st
);

  localparam int CNT_MAX = CMP_LEN + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             clkPrev;
  logic             loadPrev;
  logic [CNT_W-1:0] bitCount;
  logic             clkRise;
  logic             loadRise;
  logic             linesLow;
  logic             isRefFrame;
  logic             isCmpFrame;

  assign clkRise    = sClk & ~clkPrev;
  assign loadRise   = sLoad & ~loadPrev;
  assign linesLow   = ~sClk & ~sData;
  assign isRefFrame = (frameCode == CODE_REF) && (bitCount == CNT_W'(REF_LEN));
  assign isCmpFrame = (frameCode == CODE_CMP) && (bitCount == CNT_W'(CMP_LEN));

  always_comb begin
    st         = '0;
    st.shift   = clkRise & ~sLoad;
    st.clear   = loadRise;
    if (loadRise && linesLow) begin
      st.loadRef = isRefFrame;
      if (isCmpFrame) begin
        st.loadCmp = (framePrefix == '0);
        st.flagErr = (framePrefix != '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
      bitCount <= '0;
    end else begin
      clkPrev  <= sClk;
      loadPrev <= sLoad;
      if (st.clear)
        bitCount <= '0;
      else if (st.shift && bitCount != CNT_W'(CNT_MAX))
        bitCount <= bitCount + 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(CNT_MAX)) else $error("bit count overran"); // R8
  AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    st.clear |=> (bitCount == '0)) else $error("count not cleared"); // R9
  AST_NO_SHIFT_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    sLoad && $past(sLoad) |-> $stable(bitCount) || bitCount == '0) else $error("shift during load"); // R2

endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import synth_prog_pkg::*;
#(
  parameter int SHIFT_W = PREFIX_W + CMP_W + CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sData,
  input  dpStrobe_t           st,
  output logic [CODE_W-1:0]   frameCode,
  output logic [PREFIX_W-1:0] framePrefix,
  output logic [REF_W-1:0]    refWord,
  output logic                refValid,
  output logic [CMP_W-1:0]    cmpWord,
  output logic                cmpValid,
  output logic                prefixErr
);

  logic [SHIFT_W-1:0] shiftReg;

  assign frameCode   = shiftReg[CODE_W-1:0];
  assign framePrefix = shiftReg[SHIFT_W-1 -: PREFIX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         shiftReg <= '0;
    else if (st.clear) shiftReg <= '0;
    else if (st.shift) shiftReg <= {shiftReg[SHIFT_W-2:0], sData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refWord  <= '0;
      refValid <= 1'b0;
    end else if (st.loadRef) begin
      refWord  <= shiftReg[REF_W+CODE_W-1:CODE_W];
      refValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpWord  <= '0;
      cmpValid <= 1'b0;
    end else if (st.loadCmp) begin
      cmpWord  <= shiftReg[CMP_W+CODE_W-1:CODE_W];
      cmpValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           prefixErr <= 1'b0;
    else if (st.flagErr) prefixErr <= 1'b1;
  end

  AST_REF_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refWord) |-> $past(frameCode) == CODE_REF) else $error("ref word from bad code"); // R5
  AST_CMP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmpWord) |-> ($past(frameCode) == CODE_CMP) && ($past(framePrefix) == '0)) else $error("cmp word from bad frame"); // R6
  AST_LOAD_PREFIX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    st.loadCmp |-> framePrefix == '0) else $error("cmp load with prefix"); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    prefixErr |=> prefixErr) else $error("error flag dropped"); // R11
  AST_REF_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> refValid) else $error("ref valid dropped"); // R3
  AST_CMP_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |=> cmpValid) else $error("cmp valid dropped"); // R4
  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.loadRef, st.loadCmp, st.shift})) else $error("strobes overlap"); // R10

endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLoad,
  output logic [REF_W-1:0] refWord,
  output logic             refValid,
  output logic [CMP_W-1:0] cmpWord,
  output logic             cmpValid,
  output logic             prefixErr
);

  localparam int REF_LEN = REF_W + CODE_W;
  localparam int CMP_LEN = PREFIX_W + CMP_W + CODE_W;

  logic [2:0]          syncBus;
  logic                sClk;
  logic                sData;
  logic                sLoad;
  logic [CODE_W-1:0]   frameCode;
  logic [PREFIX_W-1:0] framePrefix;
  dpStrobe_t           st;

  sp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({serLoad, serData, serClk}),
    .syncOut (syncBus)
  );

  assign sClk  = syncBus[0];
  assign sData = syncBus[1];
  assign sLoad = syncBus[2];

  sp_ctrl #(.REF_LEN(REF_LEN), .CMP_LEN(CMP_LEN)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sClk        (sClk),
    .sData       (sData),
    .sLoad       (sLoad),
    .frameCode   (frameCode),
    .framePrefix (framePrefix),
    .st          (st)
  );

  sp_datapath #(.SHIFT_W(CMP_LEN)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sData       (sData),
    .st          (st),
    .frameCode   (frameCode),
    .framePrefix (framePrefix),
    .refWord     (refWord),
    .refValid    (refValid),
    .cmpWord     (cmpWord),
    .cmpValid    (cmpValid),
    .prefixErr   (prefixErr)
  );

endmodule

// File: tb/test_synth_prog_port.sv
module test_synth_prog_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        serLoad = 1'b0;
  logic [16:0] refWord;
  logic        refValid;
  logic [17:0] cmpWord;
  logic        cmpValid;
  logic        prefixErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [16:0] ref_w;
    logic        ref_v;
    logic [17:0] cmp_w;
    logic        cmp_v;
    logic        err;
    string       tag;
  } expect_t;

  expect_t expQ[$];
  expect_t model;
  event    frameEv;

  always #10 clk = ~clk;

  synth_prog_port i_synth_prog_port (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .refWord(refWord), .refValid(refValid), .cmpWord(cmpWord),
    .cmpValid(cmpValid), .prefixErr(prefixErr)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input expect_t e);
    check(e.tag, "refWord",   32'(refWord),   32'(e.ref_w));
    check(e.tag, "refValid",  32'(refValid),  32'(e.ref_v));
    check(e.tag, "cmpWord",   32'(cmpWord),   32'(e.cmp_w));
    check(e.tag, "cmpValid",  32'(cmpValid),  32'(e.cmp_v));
    check(e.tag, "prefixErr", 32'(prefixErr), 32'(e.err));
  endtask

  // Driver: shifts len bits MSB first, then strobes load; predicts the outcome.
  task automatic sendFrame(input logic [22:0] bits, input int len,
                           input bit dataHigh, input bit clkHigh, input string tag);
    for (int i = len - 1; i >= 0; i--) begin
      serData = bits[i];
      repeat (4) @(posedge clk);
      serClk = 1'b1;
      repeat (4) @(posedge clk);
      if (!(clkHigh && i == 0)) serClk = 1'b0;
    end
    repeat (4) @(posedge clk);
    serData = dataHigh;
    repeat (4) @(posedge clk);
    serLoad = 1'b1;
    if (!clkHigh && !dataHigh) begin
      if (len == 19 && bits[1:0] == 2'b11) begin
        model.ref_w = bits[18:2];
        model.ref_v = 1'b1;
      end else if (len == 23 && bits[1:0] == 2'b01) begin
        if (bits[22:20] == 3'b000) begin
          model.cmp_w = bits[19:2];
          model.cmp_v = 1'b1;
        end else begin
          model.err = 1'b1;
        end
      end
    end
    model.tag = tag;
    repeat (10) @(posedge clk);
    expQ.push_back(model);
    -> frameEv;
    repeat (12) @(posedge clk);
    serLoad = 1'b0;
    serClk  = 1'b0;
    serData = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  // Monitor: pops each expected snapshot and compares against the ports.
  initial begin
    forever begin
      @(frameEv);
      repeat (2) @(negedge clk);
      if (expQ.size() != 0) compareAll(expQ.pop_front());
    end
  end

  function automatic logic [22:0] refFrame(input logic [16:0] d, input logic [1:0] code);
    return {4'b0000, d, code};
  endfunction

  function automatic logic [22:0] cmpFrame(input logic [2:0] p, input logic [17:0] d, input logic [1:0] code);
    return {p, d, code};
  endfunction

  initial begin
    model = '{ref_w: '0, ref_v: 1'b0, cmp_w: '0, cmp_v: 1'b0, err: 1'b0, tag: "R1"};
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    model.tag = "R1 reset";
    compareAll(model);

    sendFrame(refFrame(17'h1A5C3, 2'b11), 19, 1'b0, 1'b0, "R3 R2 ref frame");
    sendFrame(cmpFrame(3'b000, 18'h2B3C1, 2'b01), 23, 1'b0, 1'b0, "R4 R10 cmp frame");
    sendFrame(refFrame(17'h00F0F, 2'b00), 19, 1'b0, 1'b0, "R5 code 00");
    sendFrame(cmpFrame(3'b000, 18'h15555, 2'b10), 23, 1'b0, 1'b0, "R5 code 10");
    sendFrame(cmpFrame(3'b100, 18'h3FFFF, 2'b01), 23, 1'b0, 1'b0, "R6 bad prefix");
    sendFrame(refFrame(17'h0BEEF, 2'b11), 19, 1'b1, 1'b0, "R7 data high at load");
    sendFrame(refFrame(17'h12345, 2'b11), 19, 1'b0, 1'b1, "R7 clk high at load");
    sendFrame(refFrame(17'h07777, 2'b11), 18, 1'b0, 1'b0, "R8 short frame");
    sendFrame(cmpFrame(3'b000, 18'h0AAAA, 2'b11), 23, 1'b0, 1'b0, "R8 long ref code");
    sendFrame(23'h00001F, 5, 1'b0, 1'b0, "R9 partial frame");
    sendFrame(refFrame(17'h10001, 2'b11), 19, 1'b0, 1'b0, "R9 R10 ref after partial");
    sendFrame(cmpFrame(3'b000, 18'h20003, 2'b01), 23, 1'b0, 1'b0, "R11 err holds");

    rstN = 1'b0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    model = '{ref_w: '0, ref_v: 1'b0, cmp_w: '0, cmp_v: 1'b0, err: 1'b0, tag: "R1 R11 re-reset"};
    compareAll(model);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
        repeat (5) @(posedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule